// File: doc/BRIEF.md
# Burst Splitting Controller

This block sits between a 32-bit internal system port and an external memory data path that is either 8 or 16 bits wide. It takes a single access or a fixed-length burst counted in 32-bit words. It checks the request, then breaks every word into external-width beats. The beats go out on a beat-level interface that carries an address, a data lane, a valid strobe and a last flag. For reads, the block packs the returned beats back into 32-bit words and hands them to the internal side in order.

Three configuration inputs set how the external side is driven. An access-mode bit chooses between isolated accesses and grouped (burst or page) accesses. A device-width code gives the external width. A page-length code caps how many beats one external burst may hold. A request longer than the cap is sent as several back-to-back bursts. A request shorter than the cap ends its burst early. With an 8-bit device, grouping is always off.

Top module: `burst_split_ctrl`

## Requirements
- R1: Device-width code 0 selects 8-bit and code 1 selects 16-bit. While the code is 2 or 3, every request is rejected with an error and produces no beats.
- R2: A request is legal when its word count is 1, 2, 4, 8 or 16 and its byte address is a multiple of 4 times the word count. An illegal request raises `req_err` for exactly one cycle, in the cycle after acceptance, and produces no beats.
- R3: With a 16-bit device, each word is sent as two beats, low half (bits 15:0) first. The beat address starts at the request address and rises by 2 per beat, so a request of N words gives 2N beats.
- R4: With an 8-bit device, each word is sent as four beats, least significant byte first. The byte is on `ext_wdata[7:0]` with the upper lane zero, the address rises by 1 per beat, and every beat has `ext_last` set regardless of the access-mode bit.
- R5: With access-mode bit 0 (single), every beat has `ext_last` set.
- R6: With access-mode bit 1 and a 16-bit device, beats are grouped into bursts. The group length comes from the page-length code: 0 gives 4 beats, 1 gives 8, 2 gives 16, and 3 gives 1. `ext_last` marks the final beat of each full group, and longer requests continue as consecutive groups.
- R7: The final beat of every request carries `ext_last`, so a request shorter than the group length ends its burst early.
- R8: Write words are pulled one at a time through the `wd_valid`/`wd_ready` handshake, in request order. `ext_write` is high on the beats of a write and low on the beats of a read.
- R9: For reads, returned beats are packed little-endian into 32-bit words. The 8-bit case uses `ext_rd_data[7:0]`. Words come out on `int_rd_valid` in order, and `int_rd_last` is set on the final word only.
- R10: `req_ready` is high only when no request is in progress, and it drops in the cycle after a legal request is accepted. The configuration is sampled at acceptance, so changing it mid-request has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multi | input | 1 | Access mode: 0 single, 1 grouped |
| cfg_width | input | 2 | Device width code |
| cfg_page | input | 2 | Page-length code |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address of the first word |
| req_len | input | 5 | Number of 32-bit words |
| req_err | output | 1 | One-cycle rejection pulse |
| wd_valid | input | 1 | Write word available |
| wd_ready | output | 1 | Block takes a write word |
| wd_data | input | 32 | Write word |
| ext_valid | output | 1 | External beat strobe |
| ext_write | output | 1 | Beat direction |
| ext_addr | output | ADDR_W | Beat byte address |
| ext_wdata | output | 16 | Beat write data |
| ext_last | output | 1 | Final beat of an external burst |
| ext_rd_valid | input | 1 | Returned read beat strobe |
| ext_rd_data | input | 16 | Returned read beat data |
| int_rd_valid | output | 1 | Packed read word strobe |
| int_rd_data | output | 32 | Packed read word |
| int_rd_last | output | 1 | Final word of the read |

## Verification
The splitting path is tried with writes and reads at both device widths. This separates lane order and address stride for 16-bit beats from those for byte beats. Every page-length code is combined with requests that are shorter than, equal to and longer than the group. That separates early termination from regrouping into consecutive bursts, and it shows that single mode and 8-bit devices never group. Misaligned, non-power-of-two and reserved-width requests show that rejection is quiet on the beat side. A configuration change right after acceptance shows that settings are latched.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int WORD_W = 32;
  localparam int EXT_W  = 16;
  localparam int LEN_W  = 5;
  localparam int CNT_W  = 7;

  function automatic logic width_valid(input logic [1:0] w);
    return w <= 2'd1;
  endfunction

  function automatic logic [1:0] beat_bytes(input logic [1:0] w);
    return (w == 2'd0) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] beats_per_word(input logic [1:0] w);
    return (w == 2'd0) ? 3'd4 : 3'd2;
  endfunction

  function automatic logic [4:0] page_beats(input logic [1:0] p);
    case (p)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      2'd2:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic len_legal(input logic [LEN_W-1:0] l);
    return (l == 5'd1) || (l == 5'd2) || (l == 5'd4) || (l == 5'd8) || (l == 5'd16);
  endfunction

  function automatic logic base_aligned(input logic [6:0] a, input logic [LEN_W-1:0] l);
    logic [6:0] span;
    span = {l, 2'b00};
    return (a & (span - 7'd1)) == 7'd0;
  endfunction
endpackage

// File: rtl/bsc_req_check.sv
module bsc_req_check
  import bsc_pkg::*;
(
  input  logic [6:0]       addr_lo,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       width,
  output logic             ok
);
  always_comb begin
    ok = width_valid(width) && len_legal(len) && base_aligned(addr_lo, len);
  end
endmodule

// File: rtl/bsc_beat_seq.sv
module bsc_beat_seq
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s_write,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [LEN_W-1:0]  s_len,
  input  logic              s_multi,
  input  logic [1:0]        s_width,
  input  logic [1:0]        s_page,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  input  logic              rd_done,
  output logic              busy,
  output logic              wd_ready,
  output logic              ext_valid,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [EXT_W-1:0]  ext_wdata,
  output logic              ext_last,
  output logic              ext_final,
  output logic              lat_w8,
  output logic [4:0]        lat_grp
);
  logic              wr_q, issued_q, buf_full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [4:0]        grp_q;
  logic [1:0]        sub_q;
  logic [WORD_W-1:0] buf_q;

  logic             can_issue, beat_final, grp_end, word_end;
  logic [EXT_W-1:0] lane;
  logic [1:0]       step;

  always_comb begin
    can_issue  = busy && !issued_q && (!wr_q || buf_full_q);
    beat_final = (left_q == CNT_W'(1));
    grp_end    = (grp_q == lat_grp - 5'd1);
    word_end   = lat_w8 ? (sub_q == 2'd3) : sub_q[0];
    step       = lat_w8 ? 2'd1 : 2'd2;
    if (lat_w8) lane = {8'h00, buf_q[{sub_q, 3'b000} +: 8]};
    else        lane = buf_q[{sub_q[0], 4'b0000} +: 16];
    wd_ready   = busy && wr_q && !buf_full_q && !issued_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      wr_q       <= 1'b0;
      lat_w8     <= 1'b0;
      issued_q   <= 1'b0;
      buf_full_q <= 1'b0;
      addr_q     <= '0;
      left_q     <= '0;
      grp_q      <= '0;
      lat_grp    <= 5'd1;
      sub_q      <= '0;
      buf_q      <= '0;
      ext_valid  <= 1'b0;
      ext_write  <= 1'b0;
      ext_addr   <= '0;
      ext_wdata  <= '0;
      ext_last   <= 1'b0;
      ext_final  <= 1'b0;
    end else begin
      ext_valid <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        wr_q       <= s_write;
        lat_w8     <= (s_width == 2'd0);
        issued_q   <= 1'b0;
        buf_full_q <= 1'b0;
        addr_q     <= s_addr;
        left_q     <= CNT_W'(s_len) * CNT_W'(beats_per_word(s_width));
        grp_q      <= '0;
        lat_grp    <= (s_multi && s_width == 2'd1) ? page_beats(s_page) : 5'd1;
        sub_q      <= '0;
      end else begin
        if (wd_ready && wd_valid) begin
          buf_q      <= wd_data;
          buf_full_q <= 1'b1;
        end
        if (can_issue) begin
          ext_valid <= 1'b1;
          ext_write <= wr_q;
          ext_addr  <= addr_q;
          ext_wdata <= wr_q ? lane : '0;
          ext_last  <= beat_final || grp_end;
          ext_final <= beat_final;
          grp_q     <= (beat_final || grp_end) ? 5'd0 : grp_q + 5'd1;
          addr_q    <= addr_q + ADDR_W'(step);
          left_q    <= left_q - CNT_W'(1);
          sub_q     <= word_end ? 2'd0 : sub_q + 2'd1;
          if (word_end) buf_full_q <= 1'b0;
          if (beat_final) begin
            issued_q <= 1'b1;
            if (wr_q) busy <= 1'b0;
          end
        end
        if (rd_done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsc_rd_pack.sv
module bsc_rd_pack
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s_w8,
  input  logic [LEN_W-1:0]  s_len,
  input  logic              rd_valid,
  input  logic [EXT_W-1:0]  rd_data,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_last
);
  logic              w8_q;
  logic [LEN_W-1:0]  len_q, words_q;
  logic [1:0]        lane_q;
  logic [WORD_W-1:0] acc_q, merged;
  logic              lane_end, last_word;

  always_comb begin
    merged = acc_q;
    if (w8_q) merged[{lane_q, 3'b000} +: 8] = rd_data[7:0];
    else      merged[{lane_q[0], 4'b0000} +: 16] = rd_data;
    lane_end  = w8_q ? (lane_q == 2'd3) : lane_q[0];
    last_word = (words_q == len_q - LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w8_q       <= 1'b0;
      len_q      <= '0;
      words_q    <= '0;
      lane_q     <= '0;
      acc_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_last  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      word_last  <= 1'b0;
      if (start) begin
        w8_q    <= s_w8;
        len_q   <= s_len;
        words_q <= '0;
        lane_q  <= '0;
      end else if (rd_valid) begin
        acc_q <= merged;
        if (lane_end) begin
          lane_q     <= 2'd0;
          word_valid <= 1'b1;
          word_data  <= merged;
          word_last  <= last_word;
          words_q    <= words_q + LEN_W'(1);
        end else begin
          lane_q <= lane_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/burst_split_ctrl.sv
module burst_split_ctrl
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_multi,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_page,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [4:0]        req_len,
  output logic              req_err,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [31:0]       wd_data,
  output logic              ext_valid,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [15:0]       ext_wdata,
  output logic              ext_last,
  input  logic              ext_rd_valid,
  input  logic [15:0]       ext_rd_data,
  output logic              int_rd_valid,
  output logic [31:0]       int_rd_data,
  output logic              int_rd_last
);
  logic       req_ok, accept, start, busy, err_q, rd_done;
  logic       lat_w8, ext_final;
  logic [4:0] lat_grp;

  bsc_req_check u_check (
    .addr_lo (req_addr[6:0]),
    .len     (req_len),
    .width   (cfg_width),
    .ok      (req_ok)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && req_ok;
  assign req_err   = err_q;
  assign rd_done   = int_rd_valid && int_rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && !req_ok;
  end

  bsc_beat_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .s_write   (req_write),
    .s_addr    (req_addr),
    .s_len     (req_len),
    .s_multi   (cfg_multi),
    .s_width   (cfg_width),
    .s_page    (cfg_page),
    .wd_valid  (wd_valid),
    .wd_data   (wd_data),
    .rd_done   (rd_done),
    .busy      (busy),
    .wd_ready  (wd_ready),
    .ext_valid (ext_valid),
    .ext_write (ext_write),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_last  (ext_last),
    .ext_final (ext_final),
    .lat_w8    (lat_w8),
    .lat_grp   (lat_grp)
  );

  bsc_rd_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start && !req_write),
    .s_w8       (cfg_width == 2'd0),
    .s_len      (req_len),
    .rd_valid   (ext_rd_valid),
    .rd_data    (ext_rd_data),
    .word_valid (int_rd_valid),
    .word_data  (int_rd_data),
    .word_last  (int_rd_last)
  );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic              busy,
  input logic              ext_valid,
  input logic              ext_last,
  input logic              ext_final,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              lat_w8,
  input logic [4:0]        lat_grp,
  input logic              int_rd_valid,
  input logic              int_rd_last
);
  logic [4:0]        grp_cnt;
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_cnt   <= '0;
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (ext_valid) begin
      grp_cnt   <= ext_last ? 5'd0 : grp_cnt + 5'd1;
      have_prev <= !ext_final;
      prev_addr <= ext_addr;
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !ext_valid && !busy); // R2
  AST_BYTE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && lat_w8 |-> ext_last); // R4
  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> grp_cnt < lat_grp); // R6
  AST_GROUP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && (grp_cnt == lat_grp - 5'd1) |-> ext_last); // R6
  AST_FINAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && ext_final |-> ext_last); // R7
  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && have_prev |-> ext_addr == prev_addr + (lat_w8 ? ADDR_W'(1) : ADDR_W'(2))); // R3
  AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> $past(busy)); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R10
  AST_RD_LAST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd_valid && int_rd_last |=> !int_rd_valid); // R9
endmodule

bind burst_split_ctrl bsc_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .req_err      (req_err),
  .busy         (busy),
  .ext_valid    (ext_valid),
  .ext_last     (ext_last),
  .ext_final    (ext_final),
  .ext_addr     (ext_addr),
  .lat_w8       (lat_w8),
  .lat_grp      (lat_grp),
  .int_rd_valid (int_rd_valid),
  .int_rd_last  (int_rd_last)
);

// File: tb/test_burst_split_ctrl.sv
`timescale 1ns/1ps
module test_burst_split_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_multi = 1'b1;
  logic [1:0]  cfg_width = 2'd1;
  logic [1:0]  cfg_page = 2'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic        req_err;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [31:0] wd_data = '0;
  logic        ext_valid, ext_write, ext_last;
  logic [31:0] ext_addr;
  logic [15:0] ext_wdata;
  logic        ext_rd_valid = 1'b0;
  logic [15:0] ext_rd_data = '0;
  logic        int_rd_valid, int_rd_last;
  logic [31:0] int_rd_data;

  always #2.5 clk = ~clk;

  burst_split_ctrl i_burst_split_ctrl (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] qa[$];
  logic [15:0] qd[$];
  logic        ql[$];
  logic        qw[$];
  logic [31:0] rq[$];
  logic        rl[$];
  logic [31:0] wq[$];
  logic        pend_pop = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  task automatic build(input bit w, input logic [31:0] a, input int len);
    int bpb, bpw, total, g;
    logic [31:0] word, rword;
    bpb = (cfg_width == 2'd0) ? 1 : 2;
    bpw = 4 / bpb;
    total = len * bpw;
    g = 1;
    if (cfg_multi && cfg_width == 2'd1)
      g = (cfg_page == 2'd0) ? 4 : (cfg_page == 2'd1) ? 8 : (cfg_page == 2'd2) ? 16 : 1;
    for (int i = 0; i < len; i++) begin
      word = {16'hA000 + 16'(i), a[15:0] + 16'(i * 7)};
      if (w) wq.push_back(word);
      rword = '0;
      for (int j = 0; j < bpw; j++) begin
        int idx;
        logic [31:0] ba;
        idx = i * bpw + j;
        ba = a + 32'(idx * bpb);
        qa.push_back(ba);
        qw.push_back(w);
        ql.push_back((idx == total - 1) || (idx % g == g - 1));
        if (bpb == 1) begin
          qd.push_back({8'h00, word[j*8 +: 8]});
          rword[j*8 +: 8] = resp(ba) & 16'h00FF;
        end else begin
          qd.push_back(word[j*16 +: 16]);
          rword[j*16 +: 16] = resp(ba);
        end
      end
      if (!w) begin
        rq.push_back(rword);
        rl.push_back(i == len - 1);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pend_pop && wq.size() > 0) void'(wq.pop_front());
    wd_valid = (wq.size() > 0);
    wd_data  = (wq.size() > 0) ? wq[0] : 32'h0;
    pend_pop = wd_valid && wd_ready;
    ext_rd_valid = 1'b0;
    if (rst_n && ext_valid) begin
      if (qa.size() == 0) begin
        check("R2 unexpected beat", ext_addr, 32'hFFFF_FFFF);
      end else begin
        check("R3 R4 addr", ext_addr, qa[0]);
        check("R5 R6 R7 last", 32'(ext_last), 32'(ql[0]));
        check("R8 write", 32'(ext_write), 32'(qw[0]));
        if (qw[0]) check("R3 R4 data", 32'(ext_wdata), 32'(qd[0]));
        void'(qa.pop_front()); void'(qd.pop_front());
        void'(ql.pop_front()); void'(qw.pop_front());
      end
      if (!ext_write) begin
        ext_rd_valid = 1'b1;
        ext_rd_data  = resp(ext_addr);
      end
    end
    if (rst_n && int_rd_valid) begin
      if (rq.size() == 0) begin
        check("R9 unexpected word", int_rd_data, 32'hFFFF_FFFF);
      end else begin
        check("R9 rdata", int_rd_data, rq[0]);
        check("R9 rlast", 32'(int_rd_last), 32'(rl[0]));
        void'(rq.pop_front()); void'(rl.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit w, input logic [31:0] a, input int len, input bit ok, input bit flip);
    int t;
    logic [1:0] sw, sp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (ok) build(w, a, len);
    req_write = w; req_addr = a; req_len = 5'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    sw = cfg_width; sp = cfg_page;
    if (flip) begin cfg_width = 2'd0; cfg_page = 2'd3; end
    check(ok ? "R2 no err" : "R1 R2 err pulse", 32'(req_err), 32'(!ok));
    if (ok) check("R10 ready drops", 32'(req_ready), 32'd0);
    t = 0;
    while ((qa.size() > 0 || rq.size() > 0 || !req_ready) && t < 3000) begin
      @(negedge clk); t++;
    end
    @(negedge clk); @(negedge clk);
    check("R7 all beats issued", 32'(qa.size()), 32'd0);
    check("R9 all words returned", 32'(rq.size()), 32'd0);
    if (!ok) check("R2 err single cycle", 32'(req_err), 32'd0);
    if (flip) begin cfg_width = sw; cfg_page = sp; end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset ready", 32'(req_ready), 32'd1);
    check("R10 reset beat", 32'(ext_valid), 32'd0);
    check("R9 reset word", 32'(int_rd_valid), 32'd0);
    check("R2 reset err", 32'(req_err), 32'd0);

    run(1'b1, 32'h100, 1, 1'b1, 1'b0);   // R7 early end in 16-beat page
    run(1'b1, 32'h200, 8, 1'b1, 1'b0);   // R3 one full group
    cfg_page = 2'd0;
    run(1'b1, 32'h400, 16, 1'b1, 1'b0);  // R6 regrouping by 4
    cfg_page = 2'd1;
    run(1'b0, 32'h040, 4, 1'b1, 1'b0);   // R9 read reassembly
    cfg_page = 2'd3;
    run(1'b1, 32'h060, 2, 1'b1, 1'b0);   // R6 code 3 -> single beats
    cfg_page = 2'd2; cfg_multi = 1'b0;
    run(1'b1, 32'h080, 4, 1'b1, 1'b0);   // R5 single mode
    cfg_multi = 1'b1; cfg_width = 2'd0;
    run(1'b1, 32'h080, 2, 1'b1, 1'b0);   // R4 byte beats
    run(1'b0, 32'h088, 2, 1'b1, 1'b0);   // R4 R9 byte reads
    cfg_width = 2'd1;
    run(1'b1, 32'h100, 3, 1'b0, 1'b0);   // R2 bad length
    run(1'b1, 32'h108, 4, 1'b0, 1'b0);   // R2 misaligned burst
    run(1'b0, 32'h102, 1, 1'b0, 1'b0);   // R2 misaligned word
    cfg_width = 2'd2;
    run(1'b1, 32'h000, 1, 1'b0, 1'b0);   // R1 reserved width
    cfg_width = 2'd3;
    run(1'b0, 32'h000, 2, 1'b0, 1'b0);   // R1 reserved width
    cfg_width = 2'd1;
    run(1'b1, 32'h010, 1, 1'b1, 1'b0);   // R1 recovery
    cfg_page = 2'd0;
    run(1'b0, 32'h300, 2, 1'b1, 1'b1);   // R10 config latched
    cfg_page = 2'd2;
    run(1'b1, 32'h800, 16, 1'b1, 1'b0);  // R6 two 16-beat groups
    run(1'b0, 32'h900, 16, 1'b1, 1'b0);  // R9 long read

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule